// File: doc/BRIEF.md
# Handshake Line Controller for a Parallel Port

This block controls a single handshake line of a parallel interface port. Software sets it up through a small byte-wide register bus. A global control byte holds the line enable and the polarity of both handshake lines. A port control byte selects whether the line is an edge-sensitive status input or a driven output. In output mode it also selects the output behaviour, and what that field means depends on the port submode.

As an input, an asserted edge on the line sets a sticky status flag. Software clears the flag by writing a one to it. As an output, the line can be held negated or held asserted. It can also run one of two input handshakes, both of which follow a one-entry input latch. The latch is filled by an asserted edge on the companion strobe line (H1) and emptied when the processor reads the latch address. Both external lines pass through two-flop synchronizers before any edge is detected.

Top module: `ppc_h2_ctrl`

## Requirements
- R1: While reset is high, and afterwards until written, the global control byte (address 0), port control byte (address 1) and status byte (address 2) read 0x00. Both vector bytes (addresses 3 and 4) read 0x0F. h2_out is at the negated level, 0 with default polarity, and h2_oe is 0.
- R2: Addresses 0, 1, 3 and 4 read back the last byte written. A write changes h2_out and h2_oe in the cycle that follows the write's clock edge.
- R3: When the enable bit (bit 4 of address 0) is 0, h2_out stays at the negated level whatever the port control byte holds.
- R4: When bit 5 of the port control byte is 0, h2_oe is 0 and bits 4:3 are ignored. An asserted edge on h2_in sets status bit 1 while the line is enabled, and the flag reads 1 after the third rising clock edge that follows the pin change. A negating edge does not set the flag.
- R5: Writing a byte with bit 1 set to address 2 clears the status flag, and a byte with bit 1 clear leaves it unchanged. If a set edge and a clearing write fall in the same cycle, the flag stays set.
- R6: While bit 5 of the port control byte is 1, the status flag is held clear from the clock edge after the write onward.
- R7: In submodes 00 and 01 (bits 7:6 of the port control byte) with bit 5 set, bits 4:3 = 00 drive h2 negated and 01 drive it asserted. h2_oe is 1 whenever bit 5 is 1.
- R8: In submodes 10 and 11 with bit 5 set, only bit 3 counts: 0 gives negated and 1 gives asserted. Bit 4 has no effect.
- R9: With bits 4:3 = 10 (interlocked), h2 is asserted while the input latch is empty. It negates after the third rising edge following an asserted H1 change, and asserts again in the cycle after a read of address 5.
- R10: With bits 4:3 = 11 (pulsed), a read of address 5 while the latch is full asserts h2 for exactly 4 cycles. An asserted H1 edge during the pulse ends it at the third rising edge after the H1 change.
- R11: Bit 1 of address 0 makes h2 active-low, so asserted means a low pin and negated a high one. Bit 0 of address 0 does the same for h1_in. Otherwise both lines are active-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h1_in | input | 1 | Strobe line that fills the input latch, asynchronous |
| h2_in | input | 1 | Handshake line input level, asynchronous |
| h2_out | output | 1 | Handshake line drive level |
| h2_oe | output | 1 | Handshake line output enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (addressing 5 empties the latch) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address, combinational |

## Verification
Register reads are combinational, so each read is compared in the same cycle its address is driven. Pin levels are compared in the first cycle after a write's clock edge. A change on h2_in or h1_in takes effect after the third rising edge: two synchronizer stages plus the registered result. The bench therefore waits exactly two edges, checks that nothing has moved yet, then waits one more and checks the new value. The pulse is checked in each of its four cycles after the latch-read edge and once more when it has ended.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    typedef enum logic [2:0] {
        A_GCR   = 3'd0,
        A_ACR   = 3'd1,
        A_STAT  = 3'd2,
        A_PVEC  = 3'd3,
        A_TVEC  = 3'd4,
        A_LATCH = 3'd5
    } reg_addr_e;

    localparam logic [DW-1:0] VEC_RESET = 8'h0F;

    // global control byte fields
    localparam int GCR_EN_BIT    = 4;
    localparam int GCR_H2LOW_BIT = 1;
    localparam int GCR_H1LOW_BIT = 0;
    // status byte field
    localparam int STAT_H2_BIT   = 1;

    typedef enum logic [1:0] {
        OB_NEG = 2'b00,
        OB_ASS = 2'b01,
        OB_ILK = 2'b10,
        OB_PLS = 2'b11
    } out_beh_e;

    typedef struct packed {
        logic [1:0] submode;
        logic       dir_out;
        out_beh_e   beh;
        logic [2:0] spare;
    } acr_t;

    function automatic logic pin_level(input logic asserted, input logic low_active);
        return asserted ^ low_active;
    endfunction
endpackage

// File: rtl/ppc_sync_edge.sv
module ppc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic low_active_i,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              lvl;

    assign lvl    = sync_q[STAGES-1] ^ low_active_i;
    assign edge_o = lvl & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            prev_q <= lvl;
        end
    end
endmodule

// File: rtl/ppc_hs_seq.sv
module ppc_hs_seq #(
    parameter int PULSE_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic h1_edge_i,
    input  logic latch_rd_i,
    output logic latch_full_o,
    output logic pulse_on_o
);
    localparam int CW = $clog2(PULSE_W + 1);

    logic          full_q;
    logic [CW-1:0] cnt_q;

    assign latch_full_o = full_q;
    assign pulse_on_o   = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
        end else if (h1_edge_i) begin
            full_q <= 1'b1;
        end else if (latch_rd_i) begin
            full_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (h1_edge_i) begin
            cnt_q <= '0;
        end else if (latch_rd_i && full_q) begin
            cnt_q <= CW'(PULSE_W);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // R9: a strobe edge always leaves the latch full
    assert_edge_fills_R9: assert property (@(posedge clk) disable iff (rst)
        $past(h1_edge_i) |-> latch_full_o);
    // R10: a pulse only starts after the full latch is read
    assert_pulse_start_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_on_o) |-> $past(latch_rd_i && full_q));
    // R10: a strobe edge ends any pulse
    assert_pulse_cut_R10: assert property (@(posedge clk) disable iff (rst)
        $past(h1_edge_i) |-> !pulse_on_o);
endmodule

// File: rtl/ppc_regs.sv
module ppc_regs
    import ppc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr_i,
    input  logic          bus_rd_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    input  logic          h2_edge_i,
    output logic [DW-1:0] bus_rdata_o,
    output logic          en_o,
    output logic          h1_low_o,
    output logic          h2_low_o,
    output logic          dir_out_o,
    output logic          sub_hi_o,
    output out_beh_e      beh_o,
    output logic          latch_rd_o
);
    logic [DW-1:0] gcr_q, acr_q, pvec_q, tvec_q;
    logic          flag_q;
    logic          flag_set, flag_clr;
    acr_t          acr;
    reg_addr_e     addr;

    assign addr       = reg_addr_e'(bus_addr_i);
    assign acr        = acr_t'(acr_q);
    assign en_o       = gcr_q[GCR_EN_BIT];
    assign h1_low_o   = gcr_q[GCR_H1LOW_BIT];
    assign h2_low_o   = gcr_q[GCR_H2LOW_BIT];
    assign dir_out_o  = acr.dir_out;
    assign sub_hi_o   = acr.submode[1];
    assign beh_o      = acr.beh;
    assign latch_rd_o = bus_rd_i && (addr == A_LATCH);

    assign flag_set = h2_edge_i && en_o && !acr.dir_out;
    assign flag_clr = bus_wr_i && (addr == A_STAT) && bus_wdata_i[STAT_H2_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            gcr_q  <= '0;
            acr_q  <= '0;
            pvec_q <= VEC_RESET;
            tvec_q <= VEC_RESET;
        end else if (bus_wr_i) begin
            case (addr)
                A_GCR:   gcr_q  <= bus_wdata_i;
                A_ACR:   acr_q  <= bus_wdata_i;
                A_PVEC:  pvec_q <= bus_wdata_i;
                A_TVEC:  tvec_q <= bus_wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (acr.dir_out) begin
            flag_q <= 1'b0;
        end else if (flag_set) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (addr)
            A_GCR:   bus_rdata_o = gcr_q;
            A_ACR:   bus_rdata_o = acr_q;
            A_STAT:  bus_rdata_o[STAT_H2_BIT] = flag_q;
            A_PVEC:  bus_rdata_o = pvec_q;
            A_TVEC:  bus_rdata_o = tvec_q;
            default: bus_rdata_o = '0;
        endcase
    end

    // R1: register contents right after reset
    assert_reset_vals_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (gcr_q == '0 && acr_q == '0 && !flag_q &&
                        pvec_q == VEC_RESET && tvec_q == VEC_RESET));
    // R6: output direction keeps the flag clear
    assert_out_clears_flag_R6: assert property (@(posedge clk) disable iff (rst)
        $past(acr.dir_out) |-> !flag_q);
    // R4 / R5: a qualified edge sets the flag even against a clearing write
    assert_edge_sets_R5: assert property (@(posedge clk) disable iff (rst)
        $past(flag_set) |-> flag_q);
endmodule

// File: rtl/ppc_h2_ctrl.sv
module ppc_h2_ctrl
    import ppc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_W     = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          h1_in,
    input  logic          h2_in,
    output logic          h2_out,
    output logic          h2_oe,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata
);
    localparam int NLINES = 2;

    logic     en, h1_low, h2_low, dir_out, sub_hi, latch_rd;
    logic     latch_full, pulse_on, asserted;
    out_beh_e beh;

    logic [NLINES-1:0] line_pin, line_low, line_edge;

    assign line_pin = {h2_in, h1_in};
    assign line_low = {h2_low, h1_low};

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        ppc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk          (clk),
            .rst          (rst),
            .pin_i        (line_pin[i]),
            .low_active_i (line_low[i]),
            .edge_o       (line_edge[i])
        );
    end

    ppc_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_wr_i    (bus_wr),
        .bus_rd_i    (bus_rd),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .h2_edge_i   (line_edge[1]),
        .bus_rdata_o (bus_rdata),
        .en_o        (en),
        .h1_low_o    (h1_low),
        .h2_low_o    (h2_low),
        .dir_out_o   (dir_out),
        .sub_hi_o    (sub_hi),
        .beh_o       (beh),
        .latch_rd_o  (latch_rd)
    );

    ppc_hs_seq #(.PULSE_W(PULSE_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .h1_edge_i    (line_edge[0]),
        .latch_rd_i   (latch_rd),
        .latch_full_o (latch_full),
        .pulse_on_o   (pulse_on)
    );

    always_comb begin
        asserted = 1'b0;
        if (en && dir_out) begin
            if (sub_hi) begin
                asserted = beh[0];
            end else begin
                case (beh)
                    OB_NEG:  asserted = 1'b0;
                    OB_ASS:  asserted = 1'b1;
                    OB_ILK:  asserted = !latch_full;
                    OB_PLS:  asserted = pulse_on;
                    default: asserted = 1'b0;
                endcase
            end
        end
    end

    assign h2_out = pin_level(asserted, h2_low);
    assign h2_oe  = dir_out;

    // R3: a disabled line sits at the negated level
    assert_disabled_neg_R3: assert property (@(posedge clk) disable iff (rst)
        !en |-> (h2_out == h2_low));
    // R9: interlocked mode negates the line while the latch holds data
    assert_ilk_full_R9: assert property (@(posedge clk) disable iff (rst)
        (en && dir_out && !sub_hi && beh == OB_ILK && latch_full) |-> (h2_out == h2_low));
endmodule

// File: tb/ppc_h2_ctrl_bench.sv
module ppc_h2_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       h1_in, h2_in;
    logic       h2_out, h2_oe;
    logic       bus_wr, bus_rd;
    logic [2:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        string      tag;
        int         sel;
        logic [7:0] exp;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    ppc_h2_ctrl u_ppc_h2_ctrl (
        .clk(clk), .rst(rst), .h1_in(h1_in), .h2_in(h2_in),
        .h2_out(h2_out), .h2_oe(h2_oe), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t      it;
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.sel)
                0:       act = {7'd0, h2_out};
                1:       act = {7'd0, h2_oe};
                default: act = bus_rdata;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input int sel, input logic [7:0] exp, input string tag);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic sample();
        @(negedge clk);
        #1;
    endtask

    task automatic pin(input logic o, input logic oe, input string tag);
        push(0, {7'd0, o}, tag);
        push(1, {7'd0, oe}, tag);
        sample();
    endtask

    task automatic rchk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a;
        push(2, exp, tag);
        sample();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_wr = 1'b0;
    endtask

    task automatic latch_read();
        bus_rd = 1'b1; bus_addr = 3'd5;
        tick(1);
        bus_rd = 1'b0; bus_addr = 3'd0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; h1_in = 1'b0; h2_in = 1'b0;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 3'd0; bus_wdata = 8'd0;
        tick(3);
        rst = 1'b0;
        // R1 reset state
        pin(1'b0, 1'b0, "R1 pin after reset");
        rchk(3'd0, 8'h00, "R1 gcr");
        rchk(3'd1, 8'h00, "R1 acr");
        rchk(3'd2, 8'h00, "R1 status");
        rchk(3'd3, 8'h0F, "R1 port vector");
        rchk(3'd4, 8'h0F, "R1 timer vector");
        // R2 readback
        wr(3'd3, 8'hA5); rchk(3'd3, 8'hA5, "R2 port vector");
        wr(3'd4, 8'h3C); rchk(3'd4, 8'h3C, "R2 timer vector");
        wr(3'd0, 8'h10); rchk(3'd0, 8'h10, "R2 gcr");
        // R7 / R2 output held asserted, effective right after the write edge
        wr(3'd1, 8'h28); pin(1'b1, 1'b1, "R2 R7 out asserted");
        rchk(3'd1, 8'h28, "R2 acr");
        wr(3'd1, 8'h20); pin(1'b0, 1'b1, "R7 out negated");
        // R3 disabled forces negated
        wr(3'd1, 8'h28);
        wr(3'd0, 8'h00); pin(1'b0, 1'b1, "R3 disabled high-active");
        wr(3'd0, 8'h02); pin(1'b1, 1'b1, "R3 R11 disabled low-active");
        // R4 input edge sets flag, bits 4:3 ignored
        wr(3'd0, 8'h10);
        wr(3'd1, 8'h18); pin(1'b0, 1'b0, "R4 input mode");
        tick(2);
        h2_in = 1'b1;
        tick(2); rchk(3'd2, 8'h00, "R4 flag not yet");
        tick(1); rchk(3'd2, 8'h02, "R4 flag set");
        h2_in = 1'b0;
        tick(4); rchk(3'd2, 8'h02, "R4 falling edge no effect");
        // R5 clearing
        wr(3'd2, 8'hFD); rchk(3'd2, 8'h02, "R5 write without bit1 keeps flag");
        wr(3'd2, 8'h02); rchk(3'd2, 8'h00, "R5 write-one clears");
        h2_in = 1'b1;
        tick(2);
        wr(3'd2, 8'h02); rchk(3'd2, 8'h02, "R5 set beats clear");
        // R6 output mode forces clear
        wr(3'd1, 8'h20);
        tick(1); rchk(3'd2, 8'h00, "R6 flag cleared in output");
        wr(3'd1, 8'h00);
        tick(1); rchk(3'd2, 8'h00, "R6 flag stays clear back in input");
        // R11 low-active input
        wr(3'd0, 8'h12);
        tick(3); rchk(3'd2, 8'h00, "R11 polarity change no edge");
        pin(1'b1, 1'b0, "R11 input idle high when low-active");
        tick(1);
        h2_in = 1'b0;
        tick(3); rchk(3'd2, 8'h02, "R11 falling edge asserted");
        wr(3'd1, 8'h28); pin(1'b0, 1'b1, "R11 asserted drives low");
        // R8 submode 1x
        wr(3'd0, 8'h10);
        wr(3'd1, 8'hB0); pin(1'b0, 1'b1, "R8 bit3 zero negated");
        wr(3'd1, 8'hE8); pin(1'b1, 1'b1, "R8 bit3 one asserted");
        // R9 interlocked
        wr(3'd1, 8'h30); pin(1'b1, 1'b1, "R9 empty latch asserted");
        h1_in = 1'b1;
        tick(2); pin(1'b1, 1'b1, "R9 before fill");
        tick(1); pin(1'b0, 1'b1, "R9 filled negates");
        latch_read(); pin(1'b1, 1'b1, "R9 read reasserts");
        // R10 pulsed
        wr(3'd1, 8'h38);
        h1_in = 1'b0; tick(4);
        h1_in = 1'b1; tick(3); pin(1'b0, 1'b1, "R10 idle negated");
        h1_in = 1'b0; tick(4);
        latch_read(); pin(1'b1, 1'b1, "R10 pulse cycle 1");
        tick(1); pin(1'b1, 1'b1, "R10 pulse cycle 2");
        tick(1); pin(1'b1, 1'b1, "R10 pulse cycle 3");
        tick(1); pin(1'b1, 1'b1, "R10 pulse cycle 4");
        tick(1); pin(1'b0, 1'b1, "R10 pulse over");
        h1_in = 1'b1; tick(3);
        h1_in = 1'b0; tick(4);
        latch_read(); pin(1'b1, 1'b1, "R10 second pulse start");
        h1_in = 1'b1;
        tick(1); pin(1'b1, 1'b1, "R10 second pulse holding");
        tick(1); pin(1'b1, 1'b1, "R10 before cut");
        tick(1); pin(1'b0, 1'b1, "R10 cut by strobe");
        // R1 reset mid-run
        rst = 1'b1; tick(2); rst = 1'b0;
        pin(1'b0, 1'b0, "R1 pin after second reset");
        rchk(3'd1, 8'h00, "R1 acr after second reset");
        rchk(3'd3, 8'h0F, "R1 vector after second reset");
        tick(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule